// File: doc/BRIEF.md
# Serial Control and Status Register Port

This block is the register front end of a multi-channel power-driver chip. An external host talks to it over a 16-bit full-duplex SPI link (mode 0: the serial clock idles low, the host changes data on the falling edge and the slave samples on the rising edge, most significant bit first). Each received word carries a register address, a control payload, a current-sense channel select and a status-reset request. The payload goes into one of four control registers, which the block presents to the power-stage logic as a flat bus.

The status word sent during a frame belongs to the address carried by the *previous* complete frame. Each status word holds the latched diagnostic flags of that status register, three live supply and thermal flags, and a summary error bit. Three of the four status registers are read-clear: the bits that were sent are dropped when chip select rises. The fourth keeps its flags until a status-reset request arrives. Each time flags are cleared the block pulses a per-register strobe to the fault supervisor.

The serial inputs are synchronised into the system clock domain. A state machine with the states IDLE, SHIFT, COMMIT and DROP runs each frame. IDLE goes to SHIFT on a chip-select fall, and the status word is captured at that transition. SHIFT goes to COMMIT on a chip-select rise after exactly 16 clocks, and to DROP on a rise after any other count. COMMIT and DROP both return to IDLE after one cycle. Only COMMIT updates any state.

Top module: `spi_reg_if`

## Requirements
- R1: Received word layout: bits [15:14] address, [13:11] sense select, [10] status reset, [9:0] control payload. A 16-clock frame writes the payload into control register `address`, which appears on `ctrl_flat[address*10 +: 10]` once chip select rises. The other control registers keep their values.
- R2: The status register sent in a frame is the one named by the address of the previous committed frame. After reset it is register 0.
- R3: Sent status word layout: bit 15 error summary, bit 14 supply-fail flag, bit 13 thermal-shutdown flag, bit 12 thermal-warning flag, bits [11:0] diagnostic flags. The word is shifted MSB first on `spi_miso`.
- R4: The error summary bit is 1 exactly when any diagnostic bit of that status word is 1.
- R5: Diagnostic bits outside a register's used mask always read 0. The used masks for registers 3..0 are 0x03F, 0x3FF, 0x0FF and 0xFFF.
- R6: Status registers 0, 1 and 3 clear the diagnostic bits they sent when chip select rises. Register 2 keeps them.
- R7: A one-cycle pulse on a `diag_set` bit latches that flag, and the flag stays set until it is cleared.
- R8: `sense_sel` is one-hot: codes 0–3 set bits 0–3 (bridge stages), code 4 sets bit 4 (heater switch), and codes 5–7 set no bit.
- R9: A committed frame with bit 10 set clears every status register and pulses all `clr_strobe` bits for one cycle.
- R10: A frame with a clock count other than 16 changes no control register, no sense select, no read address and no status flag.
- R11: `spi_miso_oe` is 1 only while a frame is in progress, and it is 0 while chip select is high.
- R12: After reset all control registers, `sense_sel` and `clr_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| diag_set | input | 48 | Diagnostic set pulses, 12 per status register |
| flag_psf | input | 1 | Live supply-fail flag |
| flag_tsd | input | 1 | Live thermal-shutdown flag |
| flag_tw | input | 1 | Live thermal-warning flag |
| ctrl_flat | output | 40 | Four 10-bit control registers |
| sense_sel | output | 5 | One-hot current-sense channel select |
| clr_strobe | output | 4 | Per-register flag-clear pulse to the fault supervisor |

## Verification
Every serial edge reaches the state machine two synchroniser cycles plus one edge-detect cycle after it is driven. The data-out bit therefore changes about four system cycles after a falling serial clock or a chip-select fall. Control registers, sense select and cleared flags change one cycle later than that, after a chip-select rise. The bench holds every serial level for eight system cycles and samples data-out just before the next rising serial clock. After chip select rises it waits ten cycles before it compares the registered outputs, which keeps every check clear of the latency. Clear strobes last a single cycle, so a monitor on every clock edge records them for the scenario tasks to compare.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DROP   = 2'd3
    } frame_state_e;

endpackage

// File: rtl/spi_sync_edges.sv
module spi_sync_edges #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);

    // bit 2: chip select, bit 1: serial clock, bit 0: data in
    localparam logic [2:0] IDLE_VAL = 3'b100;

    logic [2:0] chain [STAGES];
    logic [2:1] prev;
    logic [2:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= IDLE_VAL;
            prev <= IDLE_VAL[2:1];
        end else begin
            chain[0] <= {cs_n_in, sclk_in, mosi_in};
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            prev <= chain[STAGES-1][2:1];
        end
    end

    assign cur       = chain[STAGES-1];
    assign sclk_rise =  cur[1] & ~prev[1];
    assign sclk_fall = ~cur[1] &  prev[1];
    assign cs_fall   = ~cur[2] &  prev[2];
    assign cs_rise   =  cur[2] & ~prev[2];
    assign mosi_s    =  cur[0];

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_reg_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] tx_word,
    output logic [FRAME_W-1:0] rx_word,
    output logic               snap,
    output logic               commit,
    output logic               miso,
    output logic               miso_oe
);

    localparam int CNT_W = $clog2(FRAME_W + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    frame_state_e state, nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] sh_in;
    logic [FRAME_W-1:0] sh_out;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) nxt = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) nxt = (bit_cnt == CNT_FULL) ? ST_COMMIT : ST_DROP;
            ST_COMMIT: nxt = ST_IDLE;
            ST_DROP:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
            miso_oe <= 1'b0;
        end else begin
            miso_oe <= (nxt == ST_SHIFT);
            if (snap) begin
                sh_out  <= tx_word;
                sh_in   <= '0;
                bit_cnt <= '0;
            end else if (state == ST_SHIFT) begin
                if (sclk_rise) begin
                    sh_in <= {sh_in[FRAME_W-2:0], mosi_s};
                    if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                end
                if (sclk_fall) sh_out <= {sh_out[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign snap    = (state == ST_IDLE) && cs_fall;
    assign commit  = (state == ST_COMMIT);
    assign rx_word = sh_in;
    assign miso    = sh_out[FRAME_W-1];

endmodule

// File: rtl/spi_ctrl_bank.sv
module spi_ctrl_bank #(
    parameter int ADDR_W = 2,
    parameter int CTRL_W = 10,
    parameter int SEL_W  = 3,
    parameter int NSENSE = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CTRL_W-1:0]             wr_data,
    input  logic [SEL_W-1:0]              wr_sel,
    output logic [(1<<ADDR_W)*CTRL_W-1:0] ctrl_flat,
    output logic [NSENSE-1:0]             sense_sel,
    output logic [ADDR_W-1:0]             rd_addr
);

    localparam int NREG = 1 << ADDR_W;

    logic [NSENSE-1:0] sel_dec;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_flat[i*CTRL_W +: CTRL_W] <= '0;
            else if (commit && wr_addr == ADDR_W'(i))
                ctrl_flat[i*CTRL_W +: CTRL_W] <= wr_data;
        end
    end

    for (genvar k = 0; k < NSENSE; k++) begin : g_dec
        assign sel_dec[k] = (wr_sel == SEL_W'(k));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_sel <= '0;
            rd_addr   <= '0;
        end else if (commit) begin
            sense_sel <= sel_dec;
            rd_addr   <= wr_addr;
        end
    end

endmodule

// File: rtl/spi_status_bank.sv
module spi_status_bank #(
    parameter int                   NREG    = 4,
    parameter int                   ADDR_W  = 2,
    parameter int                   DIAG_W  = 12,
    parameter int                   FRAME_W = 16,
    parameter logic [NREG*DIAG_W-1:0] USED  = '1,
    parameter logic [NREG-1:0]      CLR_RD  = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG*DIAG_W-1:0] diag_set,
    input  logic                   flag_psf,
    input  logic                   flag_tsd,
    input  logic                   flag_tw,
    input  logic                   snap,
    input  logic                   commit,
    input  logic                   srr_hit,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [FRAME_W-1:0]     tx_word,
    output logic [NREG-1:0]        clr_strobe
);

    logic [DIAG_W-1:0] flags [NREG];
    logic [DIAG_W-1:0] sent_bits;
    logic [ADDR_W-1:0] sent_addr;
    logic [DIAG_W-1:0] sel_flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_bits <= '0;
            sent_addr <= '0;
        end else if (snap) begin
            sent_bits <= sel_flags;
            sent_addr <= rd_addr;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_stat
        logic              rd_clr;
        logic [DIAG_W-1:0] clr_vec;
        assign rd_clr  = commit && CLR_RD[i] && (sent_addr == ADDR_W'(i));
        assign clr_vec = srr_hit ? '1 : (rd_clr ? sent_bits : '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i]      <= '0;
                clr_strobe[i] <= 1'b0;
            end else begin
                flags[i] <= ((flags[i] & ~clr_vec) | diag_set[i*DIAG_W +: DIAG_W])
                            & USED[i*DIAG_W +: DIAG_W];
                clr_strobe[i] <= srr_hit || rd_clr;
            end
        end
    end

    assign sel_flags = flags[rd_addr];
    assign tx_word   = {|sel_flags, flag_psf, flag_tsd, flag_tw, sel_flags};

endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if #(
    parameter int FRAME_W     = 16,
    parameter int ADDR_W      = 2,
    parameter int SEL_W       = 3,
    parameter int NSENSE      = 5,
    parameter int SYNC_STAGES = 2,
    parameter logic [(1<<ADDR_W)*(FRAME_W-4)-1:0] STAT_USED = 48'h03F_3FF_0FF_FFF,
    parameter logic [(1<<ADDR_W)-1:0] CLR_ON_READ = 4'b1011
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  spi_sclk,
    input  logic                                  spi_cs_n,
    input  logic                                  spi_mosi,
    output logic                                  spi_miso,
    output logic                                  spi_miso_oe,
    input  logic [(1<<ADDR_W)*(FRAME_W-4)-1:0]    diag_set,
    input  logic                                  flag_psf,
    input  logic                                  flag_tsd,
    input  logic                                  flag_tw,
    output logic [(1<<ADDR_W)*(FRAME_W-ADDR_W-SEL_W-1)-1:0] ctrl_flat,
    output logic [NSENSE-1:0]                     sense_sel,
    output logic [(1<<ADDR_W)-1:0]                clr_strobe
);

    localparam int NREG    = 1 << ADDR_W;
    localparam int DIAG_W  = FRAME_W - 4;
    localparam int CTRL_W  = FRAME_W - ADDR_W - SEL_W - 1;
    localparam int SRR_BIT = CTRL_W;
    localparam int SEL_LO  = CTRL_W + 1;
    localparam int ADDR_LO = FRAME_W - ADDR_W;

    logic sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_s;
    logic snap, commit, srr_hit;
    logic [FRAME_W-1:0] rx_word, tx_word;
    logic [ADDR_W-1:0]  rd_addr;

    spi_sync_edges #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s)
    );

    spi_frame_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s),
        .tx_word(tx_word), .rx_word(rx_word),
        .snap(snap), .commit(commit),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    assign srr_hit = commit && rx_word[SRR_BIT];

    spi_ctrl_bank #(
        .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .SEL_W(SEL_W), .NSENSE(NSENSE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .wr_addr(rx_word[ADDR_LO +: ADDR_W]),
        .wr_data(rx_word[CTRL_W-1:0]),
        .wr_sel(rx_word[SEL_LO +: SEL_W]),
        .ctrl_flat(ctrl_flat), .sense_sel(sense_sel), .rd_addr(rd_addr)
    );

    spi_status_bank #(
        .NREG(NREG), .ADDR_W(ADDR_W), .DIAG_W(DIAG_W), .FRAME_W(FRAME_W),
        .USED(STAT_USED), .CLR_RD(CLR_ON_READ)
    ) u_stat (
        .clk(clk), .rst_n(rst_n), .diag_set(diag_set),
        .flag_psf(flag_psf), .flag_tsd(flag_tsd), .flag_tw(flag_tw),
        .snap(snap), .commit(commit), .srr_hit(srr_hit), .rd_addr(rd_addr),
        .tx_word(tx_word), .clr_strobe(clr_strobe)
    );

endmodule

// File: rtl/spi_reg_if_chk.sv
module spi_reg_if_chk #(
    parameter int NREG    = 4,
    parameter int ADDR_W  = 2,
    parameter int DIAG_W  = 12,
    parameter int FRAME_W = 16,
    parameter int CTRL_W  = 10,
    parameter int NSENSE  = 5,
    parameter logic [NREG*DIAG_W-1:0] USED = '1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     spi_cs_n,
    input logic                     spi_miso_oe,
    input logic [NSENSE-1:0]        sense_sel,
    input logic [NREG*CTRL_W-1:0]   ctrl_flat,
    input logic                     commit,
    input logic [NREG-1:0]          clr_strobe,
    input logic [FRAME_W-1:0]       tx_word,
    input logic [ADDR_W-1:0]        rd_addr
);

    logic [DIAG_W-1:0] used_now;
    assign used_now = USED[rd_addr*DIAG_W +: DIAG_W];

    assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4)) |-> !spi_miso_oe);

    assert_sense_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sense_sel));

    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ctrl_flat) && $stable(sense_sel) && $stable(rd_addr)));

    assert_strobe_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_strobe != '0) |-> $past(commit));

    assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_word[DIAG_W-1:0] & ~used_now) == '0);

    assert_no_oe_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !spi_miso_oe);

endmodule

bind spi_reg_if spi_reg_if_chk #(
    .NREG(NREG), .ADDR_W(ADDR_W), .DIAG_W(DIAG_W), .FRAME_W(FRAME_W),
    .CTRL_W(CTRL_W), .NSENSE(NSENSE), .USED(STAT_USED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
    .sense_sel(sense_sel), .ctrl_flat(ctrl_flat), .commit(commit),
    .clr_strobe(clr_strobe), .tx_word(tx_word), .rd_addr(rd_addr)
);

// File: tb/tb_spi_reg_if.sv
module tb_spi_reg_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [47:0] diag_set = '0;
    logic        flag_psf = 1'b0;
    logic        flag_tsd = 1'b0;
    logic        flag_tw = 1'b0;
    logic [39:0] ctrl_flat;
    logic [4:0]  sense_sel;
    logic [3:0]  clr_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int strobe_events = 0;
    logic [3:0] last_strobe = '0;
    logic oe_mid = 1'b0;
    logic [39:0] exp_ctrl = '0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    spi_reg_if dut (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .diag_set(diag_set), .flag_psf(flag_psf), .flag_tsd(flag_tsd), .flag_tw(flag_tw),
        .ctrl_flat(ctrl_flat), .sense_sel(sense_sel), .clr_strobe(clr_strobe)
    );

    always @(posedge clk) begin
        if (clr_strobe != 4'b0) begin
            strobe_events <= strobe_events + 1;
            last_strobe   <= clr_strobe;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int addr, input int sel, input bit srr,
                                        input logic [9:0] data);
        return {addr[1:0], sel[2:0], srr, data};
    endfunction

    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? tx[15-i] : 1'b0;
            repeat (8) @(negedge clk);
            if (i < 16) rx[15-i] = spi_miso;
            if (i == 0) oe_mid = spi_miso_oe;
            spi_sclk = 1'b1;
            repeat (8) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic frame(input int addr, input int sel, input bit srr,
                         input logic [9:0] data, output logic [15:0] rx);
        xfer(mk(addr, sel, srr, data), 16, rx);
        exp_ctrl[addr*10 +: 10] = data;
    endtask

    task automatic pulse_diag(input int r, input int b);
        @(negedge clk) diag_set[r*12 + b] = 1'b1;
        @(negedge clk) diag_set[r*12 + b] = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 ctrl after reset", ctrl_flat, 0);
        check("R12 sense after reset", sense_sel, 0);
        check("R12 strobe after reset", clr_strobe, 0);
        check("R11 oe idle after reset", spi_miso_oe, 0);
    endtask

    task automatic t_ctrl_write;
        logic [15:0] rx;
        frame(1, 2, 0, 10'h2A5, rx);
        check("R2 first frame returns empty reg0", rx, 16'h0000);
        check("R1 write ctrl reg1", ctrl_flat, exp_ctrl);
        frame(3, 0, 0, 10'h155, rx);
        check("R1 write ctrl reg3, reg1 kept", ctrl_flat, exp_ctrl);
        check("R11 oe high inside frame", oe_mid, 1);
    endtask

    task automatic t_readback;
        logic [15:0] rx;
        pulse_diag(2, 3);
        repeat (20) @(negedge clk);
        frame(2, 0, 0, 10'h001, rx);
        check("R2 addr3 selected by previous frame", rx, 16'h0000);
        frame(0, 0, 0, 10'h000, rx);
        check("R3 R4 R7 reg2 word with error summary", rx, 16'h8008);
        frame(2, 0, 0, 10'h001, rx);
        frame(2, 0, 0, 10'h001, rx);
        check("R6 reg2 not cleared by reading", rx, 16'h8008);
    endtask

    task automatic t_clear_on_read;
        logic [15:0] rx;
        pulse_diag(0, 5);
        frame(0, 0, 0, 10'h000, rx);
        frame(0, 0, 0, 10'h000, rx);
        check("R7 reg0 latched flag", rx, 16'h8020);
        check("R6 strobe for reg0 read", last_strobe, 4'b0001);
        frame(0, 0, 0, 10'h000, rx);
        check("R6 reg0 cleared after read", rx, 16'h0000);
    endtask

    task automatic t_unused;
        logic [15:0] rx;
        pulse_diag(1, 10);
        pulse_diag(1, 2);
        frame(1, 0, 0, 10'h2A5, rx);
        frame(1, 0, 0, 10'h2A5, rx);
        check("R5 unused reg1 bit reads zero", rx, 16'h8004);
        pulse_diag(1, 9);
        frame(1, 0, 0, 10'h2A5, rx);
        check("R5 R4 unused-only reg1 gives no error", rx, 16'h0000);
    endtask

    task automatic t_global;
        logic [15:0] rx;
        flag_psf = 1'b1; flag_tw = 1'b1;
        frame(1, 0, 0, 10'h2A5, rx);
        check("R3 supply and warning bits", rx, 16'h5000);
        flag_psf = 1'b0; flag_tw = 1'b0; flag_tsd = 1'b1;
        frame(3, 0, 0, 10'h155, rx);
        check("R3 shutdown bit", rx, 16'h2000);
        flag_tsd = 1'b0;
    endtask

    task automatic t_sense;
        logic [15:0] rx;
        for (int s = 0; s < 8; s++) begin
            frame(3, s, 0, 10'h155, rx);
            check($sformatf("R8 sense code %0d", s), sense_sel,
                  (s < 5) ? (64'd1 << s) : 64'd0);
        end
    endtask

    task automatic t_short;
        logic [15:0] rx;
        logic [4:0]  sense_before;
        pulse_diag(0, 1);
        frame(0, 1, 0, 10'h0F0, rx);
        sense_before = sense_sel;
        xfer(mk(2, 4, 1, 10'h3FF), 12, rx);
        check("R10 short frame ctrl unchanged", ctrl_flat, exp_ctrl);
        check("R10 short frame sense unchanged", sense_sel, sense_before);
        xfer(mk(2, 4, 1, 10'h3FF), 17, rx);
        check("R10 long frame ctrl unchanged", ctrl_flat, exp_ctrl);
        frame(3, 1, 0, 10'h155, rx);
        check("R10 read address and reg0 flag kept", rx, 16'h8002);
    endtask

    task automatic t_srr;
        logic [15:0] rx;
        int ev;
        pulse_diag(3, 4);
        ev = strobe_events;
        frame(1, 0, 1, 10'h2A5, rx);
        check("R9 all strobes pulse once", last_strobe, 4'b1111);
        check("R9 one strobe event", strobe_events - ev, 1);
        frame(2, 0, 0, 10'h001, rx);
        frame(3, 0, 0, 10'h155, rx);
        check("R9 reg2 cleared by reset bit", rx, 16'h0000);
        frame(0, 0, 0, 10'h000, rx);
        check("R9 reg3 cleared by reset bit", rx, 16'h0000);
        check("R11 oe low after frames", spi_miso_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_ctrl_write();
        t_readback();
        t_clear_on_read();
        t_unused();
        t_global();
        t_sense();
        t_short();
        t_srr();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule